// File: doc/BRIEF.md
# Two-Bank Pin Controller with Edge Interrupts

This block is a memory-mapped general-purpose pin controller for 32 pads, organised as two banks of 16 pins that share one set of 32-bit registers. Every pin has a direction bit and an output latch. The latch is never written directly. Software raises bits through a set register and lowers them through a clear register, so concurrent owners of different pins never need a read-modify-write sequence.

Pad inputs pass through a two-stage synchronizer and can be read back for every pin, including pins that drive. The synchronized level is compared with its previous sample to find rising and falling edges. Each edge type has a per-pin enable mask, and each mask is also changed only through a set/clear register pair. Enabled edges are latched in a status register whose bits are cleared by writing ones. Each bank has its own interrupt line, which is the OR of that bank's 16 status bits, gated by a per-bank enable bit.

The register bus is a simple single-cycle port. A write takes effect at the clock edge where select and write are both high. A read returns data combinationally in the cycle where select is high and write is low.

Top module: `pin_bank_ctrl`

## Requirements
- R1: The direction register at byte offset 0x10 is read/write and resets to all ones. A 1 makes the pin an input, a 0 makes it an output, and each pad output enable `padOe[i]` equals the inverse of direction bit i.
- R2: The output latch resets to 0 and drives `padOut`. A write to offset 0x18 sets every latch bit whose data bit is 1. A write to 0x1C clears every latch bit whose data bit is 1. Zero data bits leave the latch unchanged. Reads of 0x14, 0x18 and 0x1C all return the latch.
- R3: A write to offset 0x14 has no effect on the output latch.
- R4: A read of offset 0x20 returns the synchronized pad level of every pin, including pins configured as outputs.
- R5: Pad inputs pass through two synchronizer stages. A read in the clock cycle right after a pad change returns the previous level.
- R6: The rising-edge enable mask is set through 0x24 and cleared through 0x28. The falling-edge enable mask is set through 0x2C and cleared through 0x30. Both masks reset to all zeros, and a read of either register in a pair returns that pair's mask.
- R7: Status register 0x34 sets bit i when pin i shows an enabled edge. A rising edge is synchronized level 1 with previous sample 0, and a falling edge is the reverse. The bit becomes visible three clocks after the pad changes. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R8: The bank enable register at 0x08 holds bit 0 for the low bank (pins 15:0) and bit 1 for the high bank (pins 31:16), and resets to 0. `bankIrq[b]` is high exactly when enable bit b is set and any status bit of bank b is set.
- R9: When a status bit is cleared in the same cycle that a new enabled edge is detected on that pin, the bit stays set.
- R10: An edge whose type is not enabled for that pin leaves the status bit clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Register access in this cycle |
| busWrite | input | 1 | 1 for write, 0 for read |
| busAddr | input | 8 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid while busSel is high and busWrite is low |
| padIn | input | 32 | Asynchronous pad levels |
| padOut | output | 32 | Pad output values |
| padOe | output | 32 | Pad output enables, 1 drives |
| bankIrq | output | 2 | Per-bank interrupt lines |

## Verification
The bench targets a status clear that lands in the same cycle as a new edge on the same pin. A design that lets the clear win would lose that interrupt and read back 0. It checks that an edge of a type not enabled for that pin leaves status clear, and that a rising-only pin ignores its fall. A design that treats both edge types alike would latch spurious events. It reads the input register one cycle after a pad change, where a design without the second synchronizer stage would already show the new level. It also writes to the read-only latch view and checks that `padOut` does not move. A design that decoded that offset as a plain latch write would change the outputs.

// File: rtl/pin_bank_pkg.sv
package pin_bank_pkg;

  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFF_BANKEN   = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_DIR      = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_OUT      = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_SET      = 8'h18;
  localparam logic [ADDR_W-1:0] OFF_CLR      = 8'h1C;
  localparam logic [ADDR_W-1:0] OFF_IN       = 8'h20;
  localparam logic [ADDR_W-1:0] OFF_RISE_SET = 8'h24;
  localparam logic [ADDR_W-1:0] OFF_RISE_CLR = 8'h28;
  localparam logic [ADDR_W-1:0] OFF_FALL_SET = 8'h2C;
  localparam logic [ADDR_W-1:0] OFF_FALL_CLR = 8'h30;
  localparam logic [ADDR_W-1:0] OFF_STAT     = 8'h34;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_BANKEN,
    SEL_DIR,
    SEL_OUT,
    SEL_SET,
    SEL_CLR,
    SEL_IN,
    SEL_RISE_SET,
    SEL_RISE_CLR,
    SEL_FALL_SET,
    SEL_FALL_CLR,
    SEL_STAT
  } regSel_e;

  typedef struct packed {
    logic    wr;
    logic    rd;
    regSel_e sel;
  } ctlStrobe_t;

  function automatic regSel_e decodeAddr(input logic [ADDR_W-1:0] a);
    regSel_e s;
    case (a)
      OFF_BANKEN:   s = SEL_BANKEN;
      OFF_DIR:      s = SEL_DIR;
      OFF_OUT:      s = SEL_OUT;
      OFF_SET:      s = SEL_SET;
      OFF_CLR:      s = SEL_CLR;
      OFF_IN:       s = SEL_IN;
      OFF_RISE_SET: s = SEL_RISE_SET;
      OFF_RISE_CLR: s = SEL_RISE_CLR;
      OFF_FALL_SET: s = SEL_FALL_SET;
      OFF_FALL_CLR: s = SEL_FALL_CLR;
      OFF_STAT:     s = SEL_STAT;
      default:      s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/pin_bank_decode.sv
module pin_bank_decode
  import pin_bank_pkg::*;
(
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output ctlStrobe_t        ctl
);

  always_comb begin
    ctl.wr  = busSel & busWrite;
    ctl.rd  = busSel & ~busWrite;
    ctl.sel = busSel ? decodeAddr(busAddr) : SEL_NONE;
  end

endmodule

// File: rtl/pin_bank_datapath.sv
module pin_bank_datapath
  import pin_bank_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int BANK_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ctlStrobe_t                  ctl,
  input  logic [NUM_PINS-1:0]         busWdata,
  output logic [NUM_PINS-1:0]         busRdata,
  input  logic [NUM_PINS-1:0]         padIn,
  output logic [NUM_PINS-1:0]         padOut,
  output logic [NUM_PINS-1:0]         padOe,
  output logic [NUM_PINS/BANK_W-1:0]  bankIrq
);

  localparam int NUM_BANKS = NUM_PINS / BANK_W;

  logic [NUM_PINS-1:0]  dirQ;
  logic [NUM_PINS-1:0]  outQ;
  logic [NUM_PINS-1:0]  riseEnQ;
  logic [NUM_PINS-1:0]  fallEnQ;
  logic [NUM_PINS-1:0]  statQ;
  logic [NUM_PINS-1:0]  prevQ;
  logic [NUM_BANKS-1:0] bankEnQ;
  logic [NUM_PINS-1:0]  syncQ [SYNC_STAGES];
  logic [NUM_PINS-1:0]  curLevel;
  logic [NUM_PINS-1:0]  riseHit;
  logic [NUM_PINS-1:0]  fallHit;
  logic [NUM_PINS-1:0]  statClr;

  // input synchronizer chain
  always_ff @(posedge clk) begin
    if (!rstN) syncQ[0] <= '0;
    else       syncQ[0] <= padIn;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rstN) syncQ[s] <= '0;
      else       syncQ[s] <= syncQ[s-1];
    end
  end

  assign curLevel = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) prevQ <= '0;
    else       prevQ <= curLevel;
  end

  // edge detection and status
  assign riseHit = curLevel & ~prevQ & riseEnQ;
  assign fallHit = ~curLevel & prevQ & fallEnQ;
  assign statClr = (ctl.wr && ctl.sel == SEL_STAT) ? busWdata : '0;

  always_ff @(posedge clk) begin
    if (!rstN) statQ <= '0;
    else       statQ <= (statQ & ~statClr) | riseHit | fallHit;
  end

  // control registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirQ    <= '1;
      outQ    <= '0;
      riseEnQ <= '0;
      fallEnQ <= '0;
      bankEnQ <= '0;
    end else if (ctl.wr) begin
      case (ctl.sel)
        SEL_DIR:      dirQ    <= busWdata;
        SEL_SET:      outQ    <= outQ | busWdata;
        SEL_CLR:      outQ    <= outQ & ~busWdata;
        SEL_RISE_SET: riseEnQ <= riseEnQ | busWdata;
        SEL_RISE_CLR: riseEnQ <= riseEnQ & ~busWdata;
        SEL_FALL_SET: fallEnQ <= fallEnQ | busWdata;
        SEL_FALL_CLR: fallEnQ <= fallEnQ & ~busWdata;
        SEL_BANKEN:   bankEnQ <= busWdata[NUM_BANKS-1:0];
        default:      ;
      endcase
    end
  end

  // read mux
  always_comb begin
    busRdata = '0;
    if (ctl.rd) begin
      case (ctl.sel)
        SEL_BANKEN:                        busRdata[NUM_BANKS-1:0] = bankEnQ;
        SEL_DIR:                           busRdata = dirQ;
        SEL_OUT, SEL_SET, SEL_CLR:         busRdata = outQ;
        SEL_IN:                            busRdata = curLevel;
        SEL_RISE_SET, SEL_RISE_CLR:        busRdata = riseEnQ;
        SEL_FALL_SET, SEL_FALL_CLR:        busRdata = fallEnQ;
        SEL_STAT:                          busRdata = statQ;
        default:                           busRdata = '0;
      endcase
    end
  end

  assign padOut = outQ;
  assign padOe  = ~dirQ;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bankIrq[b] = bankEnQ[b] & (|statQ[b*BANK_W +: BANK_W]);
  end

endmodule

// File: rtl/pin_bank_ctrl.sv
module pin_bank_ctrl
  import pin_bank_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int BANK_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       busSel,
  input  logic                       busWrite,
  input  logic [ADDR_W-1:0]          busAddr,
  input  logic [NUM_PINS-1:0]        busWdata,
  output logic [NUM_PINS-1:0]        busRdata,
  input  logic [NUM_PINS-1:0]        padIn,
  output logic [NUM_PINS-1:0]        padOut,
  output logic [NUM_PINS-1:0]        padOe,
  output logic [NUM_PINS/BANK_W-1:0] bankIrq
);

  ctlStrobe_t ctl;

  pin_bank_decode u_decode (
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .ctl      (ctl)
  );

  pin_bank_datapath #(
    .NUM_PINS    (NUM_PINS),
    .BANK_W      (BANK_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .padIn    (padIn),
    .padOut   (padOut),
    .padOe    (padOe),
    .bankIrq  (bankIrq)
  );

endmodule

// File: rtl/pin_bank_chk.sv
module pin_bank_chk
  import pin_bank_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int BANK_W   = 16
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       busSel,
  input logic                       busWrite,
  input logic [ADDR_W-1:0]          busAddr,
  input logic [NUM_PINS-1:0]        busWdata,
  input logic [NUM_PINS-1:0]        padOut,
  input logic [NUM_PINS-1:0]        padOe,
  input logic [NUM_PINS/BANK_W-1:0] bankIrq
);

  // R1
  dir_to_oe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWrite && busAddr == OFF_DIR) |=> (padOe == ~$past(busWdata)));

  // R2
  set_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWrite && busAddr == OFF_SET) |=>
      ((padOut & $past(busWdata)) == $past(busWdata)));

  // R2
  clr_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWrite && busAddr == OFF_CLR) |=> ((padOut & $past(busWdata)) == '0));

  // R3
  out_view_ro_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWrite && busAddr == OFF_OUT) |=> $stable(padOut));

  // R8
  bank_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWrite && busAddr == OFF_BANKEN && busWdata[NUM_PINS/BANK_W-1:0] == '0)
      |=> (bankIrq == '0));

endmodule

bind pin_bank_ctrl pin_bank_chk #(
  .NUM_PINS (NUM_PINS),
  .BANK_W   (BANK_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busSel   (busSel),
  .busWrite (busWrite),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .padOut   (padOut),
  .padOe    (padOe),
  .bankIrq  (bankIrq)
);

// File: tb/test_pin_bank_ctrl.sv
module test_pin_bank_ctrl;
  import pin_bank_pkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [31:0] padIn = '0;
  logic [31:0] padOut;
  logic [31:0] padOe;
  logic [1:0]  bankIrq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] expQ[$];
  string       tagQ[$];

  always #10 clk = ~clk;

  pin_bank_ctrl i_pin_bank_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .padIn(padIn), .padOut(padOut), .padOe(padOe), .bankIrq(bankIrq)
  );

  task automatic checkVal(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // monitor: compare each read against the scoreboard queue
  always @(negedge clk) begin
    if (rstN && busSel && !busWrite) begin
      if (expQ.size() == 0) begin
        checkVal("scoreboard-empty", busRdata, 32'hxxxxxxxx);
      end else begin
        logic [31:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        checkVal(t, busRdata, e);
      end
    end
  end

  task automatic regWrite(logic [7:0] a, logic [31:0] d);
    @(posedge clk); #1;
    busSel = 1; busWrite = 1; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    busSel = 0; busWrite = 0;
  endtask

  task automatic regRead(logic [7:0] a, logic [31:0] e, string tag);
    @(posedge clk); #1;
    busSel = 1; busWrite = 0; busAddr = a;
    expQ.push_back(e);
    tagQ.push_back(tag);
    @(posedge clk); #1;
    busSel = 0;
  endtask

  task automatic setPads(logic [31:0] v);
    @(posedge clk); #1;
    padIn = v;
    repeat (4) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // reset state
    checkVal("R1 reset oe", padOe, 32'h0);
    checkVal("R2 reset out", padOut, 32'h0);
    checkVal("R8 reset irq", {30'b0, bankIrq}, 32'h0);
    regRead(OFF_DIR, 32'hFFFF_FFFF, "R1 reset dir");
    regRead(OFF_RISE_SET, 32'h0, "R6 reset rise mask");
    regRead(OFF_FALL_CLR, 32'h0, "R6 reset fall mask");
    regRead(OFF_BANKEN, 32'h0, "R8 reset bank enable");

    // direction
    regWrite(OFF_DIR, 32'hFFFF_0000);
    checkVal("R1 oe", padOe, 32'h0000_FFFF);
    regRead(OFF_DIR, 32'hFFFF_0000, "R1 dir readback");

    // set / clear latch
    regWrite(OFF_SET, 32'h0000_00F0);
    checkVal("R2 set", padOut, 32'h0000_00F0);
    regWrite(OFF_CLR, 32'h0000_0030);
    checkVal("R2 clr", padOut, 32'h0000_00C0);
    regRead(OFF_OUT, 32'h0000_00C0, "R2 out view");
    regRead(OFF_SET, 32'h0000_00C0, "R2 set view");
    regRead(OFF_CLR, 32'h0000_00C0, "R2 clr view");

    // read-only latch view
    regWrite(OFF_OUT, 32'hFFFF_FFFF);
    checkVal("R3 out write ignored", padOut, 32'h0000_00C0);

    // input synchronizer
    @(posedge clk); #1;
    padIn = 32'h1234_5678;
    regRead(OFF_IN, 32'h0, "R5 sync latency");
    repeat (3) @(posedge clk);
    regRead(OFF_IN, 32'h1234_5678, "R4 input view");
    setPads(32'h0);
    regWrite(OFF_STAT, 32'hFFFF_FFFF);
    regRead(OFF_STAT, 32'h0, "R10 no edges with masks clear");

    // edge masks and status
    regWrite(OFF_RISE_SET, 32'h0000_0001);
    regWrite(OFF_FALL_SET, 32'h0002_0000);
    regWrite(OFF_BANKEN, 32'h3);
    regRead(OFF_RISE_CLR, 32'h0000_0001, "R6 rise mask");
    regRead(OFF_FALL_SET, 32'h0002_0000, "R6 fall mask");
    setPads(32'h0002_0001);
    regRead(OFF_STAT, 32'h0000_0001, "R10 rise on fall-only pin");
    checkVal("R8 low bank irq", {30'b0, bankIrq}, 32'h1);
    setPads(32'h0000_0001);
    regRead(OFF_STAT, 32'h0002_0001, "R7 fall edge");
    checkVal("R8 both irq", {30'b0, bankIrq}, 32'h3);
    setPads(32'h0);
    regRead(OFF_STAT, 32'h0002_0001, "R10 fall on rise-only pin");

    // bank gating
    regWrite(OFF_BANKEN, 32'h2);
    checkVal("R8 high only", {30'b0, bankIrq}, 32'h2);
    regWrite(OFF_BANKEN, 32'h0);
    checkVal("R8 none", {30'b0, bankIrq}, 32'h0);
    regWrite(OFF_BANKEN, 32'h3);

    // write one to clear
    regWrite(OFF_STAT, 32'h0000_0001);
    regRead(OFF_STAT, 32'h0002_0000, "R7 w1c");
    checkVal("R8 after clear", {30'b0, bankIrq}, 32'h2);
    regWrite(OFF_STAT, 32'h0002_0000);
    checkVal("R8 all clear", {30'b0, bankIrq}, 32'h0);

    // disabling a rise enable
    regWrite(OFF_RISE_CLR, 32'h0000_0001);
    regRead(OFF_RISE_SET, 32'h0, "R6 rise clr");
    setPads(32'h0000_0001);
    regRead(OFF_STAT, 32'h0, "R10 disabled rise");
    setPads(32'h0);

    // both edges on one pin
    regWrite(OFF_RISE_SET, 32'h0000_0020);
    regWrite(OFF_FALL_SET, 32'h0000_0020);
    setPads(32'h0000_0020);
    regRead(OFF_STAT, 32'h0000_0020, "R7 both rise");
    regWrite(OFF_STAT, 32'h0000_0020);
    setPads(32'h0);
    regRead(OFF_STAT, 32'h0000_0020, "R7 both fall");
    regWrite(OFF_STAT, 32'h0000_0020);

    // clear colliding with a new edge
    regWrite(OFF_RISE_SET, 32'h0000_0008);
    setPads(32'h0000_0008);
    setPads(32'h0);
    regRead(OFF_STAT, 32'h0000_0008, "R7 first edge");
    @(posedge clk); #1;
    padIn = 32'h0000_0008;
    @(posedge clk);
    regWrite(OFF_STAT, 32'h0000_0008);
    regRead(OFF_STAT, 32'h0000_0008, "R9 edge wins over clear");
    regWrite(OFF_STAT, 32'h0000_0008);
    regRead(OFF_STAT, 32'h0, "R9 later clear");

    repeat (2) @(posedge clk);
    checkVal("scoreboard drained", expQ.size(), 32'h0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule